// File: doc/BRIEF.md
# Balanced Adder-Tree Unsigned Multiplier

This block multiplies two unsigned operands and returns their full-width product. Each bit of the first operand gates the whole second operand, which gives one partial product per bit. These partial products are reduced in a balanced binary tree of adders with log2(WIDTH) levels instead of a chain of adders. No shifter is built. The relative weight between the two operands of each adder is created by appending zero bits below the more significant operand. At the first level the shift is one position, and it doubles at each level after that.

The default configuration has 8-bit operands, a 16-bit product and no registers, so the block is purely combinational. A bit mask parameter can place a register cut after any tree level, which puts pipelining inside the multiplier. A valid flag travels with the data through the same cuts, so a caller always knows which output cycle belongs to which input. Each adder is sized so that the largest value it can hold never loses a carry. A node at level k is WIDTH + 2^k bits wide, and the last level is exactly 2·WIDTH bits wide.

Top module: `mul_tree`

## Requirements
- R1: For every pair of operands op_a, op_b, res_prod equals the exact unsigned product op_a·op_b, zero-extended to 2·WIDTH bits.
- R2: The product is formed from one partial product per bit of op_a. When op_a has exactly one bit i set, res_prod equals op_b shifted left by i positions.
- R3: If either operand is zero, res_prod is zero.
- R4: No carry is lost at any level. With all-ones operands (255·255 at WIDTH=8), res_prod is exactly 65025 (0xFE01), and res_prod never exceeds (2^WIDTH−1)^2.
- R5: res_valid reproduces op_valid delayed by LATENCY clock edges, where LATENCY is the number of set bits in CUT_MASK. With the default CUT_MASK of 0, res_valid equals op_valid in the same cycle.
- R6: With register cuts, one new operand pair can be accepted on every cycle. The product for the pair presented before a rising edge appears on res_prod LATENCY edges later, and back-to-back inputs produce back-to-back results.
- R7: With at least one cut, the active-low asynchronous reset clears every cut register. While reset is held, res_valid is 0 and res_prod is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional cut registers |
| rst_n | input | 1 | Active-low asynchronous reset of the cut registers |
| op_valid | input | 1 | Marks op_a and op_b as a valid operand pair |
| op_a | input | WIDTH | Multiplier operand; its bits gate the partial products |
| op_b | input | WIDTH | Multiplicand operand |
| res_valid | output | 1 | Marks res_prod as a valid product |
| res_prod | output | 2·WIDTH | Unsigned product |

## Verification
A wrong zero padding or a narrow adder at one level changes res_prod only for operand pairs that use that level's upper bits or carries. For that reason the default configuration is swept over all 65536 operand pairs, and a one-hot, zero or all-ones operand points to the faulty level directly. In the combinational configuration a fault shows on the same cycle. In a pipelined instance a misplaced cut or an unaligned valid shows at the ports as res_valid arriving one edge early or late, or as a product that belongs to the neighbouring input, exactly LATENCY edges after the input.

// File: rtl/mul_tree_pkg.sv
package mul_tree_pkg;

   // Width of one tree node after level k (level 0 = raw partial products).
   // A node at level k covers 2^k bits of op_a, so its value is at most
   // (2^(2^k)-1)*(2^W-1), which needs W + 2^k bits.
   function automatic int node_w(input int w, input int k);
      return (k == 0) ? w : w + (1 << k);
   endfunction

   // Number of register cuts selected by a mask over 'levels' tree levels.
   function automatic int cut_count(input int mask, input int levels);
      int n;
      n = 0;
      for (int i = 0; i < levels; i++) begin
         if (((mask >> i) & 1) != 0) n++;
      end
      return n;
   endfunction

endpackage

// File: rtl/mul_tree_pp.sv
module mul_tree_pp #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0]       op_a,
   input  logic [WIDTH-1:0]       op_b,
   output logic [WIDTH*WIDTH-1:0] pp_bus
);

   initial begin
      assert (WIDTH >= 2) else $error("mul_tree_pp: WIDTH must be at least 2");
   end

   // One gated copy of op_b per bit of op_a, no shift applied here.
   for (genvar i = 0; i < WIDTH; i++) begin : g_pp
      assign pp_bus[i*WIDTH +: WIDTH] = op_b & {WIDTH{op_a[i]}};
   end

endmodule

// File: rtl/mul_tree_level.sv
module mul_tree_level #(
   parameter int IN_W     = 8,
   parameter int OUT_W    = 10,
   parameter int NODES_IN = 8,
   parameter int SH       = 1,
   parameter bit CUT      = 1'b0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            in_v,
   input  logic [NODES_IN*IN_W-1:0]        in_bus,
   output logic                            out_v,
   output logic [(NODES_IN/2)*OUT_W-1:0]   out_bus
);

   localparam int NODES_OUT = NODES_IN / 2;

   initial begin
      assert (NODES_IN >= 2 && NODES_IN % 2 == 0)
         else $error("mul_tree_level: NODES_IN must be even and at least 2");
      assert (SH >= 1) else $error("mul_tree_level: SH must be at least 1");
      assert (OUT_W >= IN_W + SH)
         else $error("mul_tree_level: OUT_W too narrow for shifted operand");
   end

   logic [NODES_OUT*OUT_W-1:0] sum_bus;

   for (genvar n = 0; n < NODES_OUT; n++) begin : g_pair
      logic [OUT_W-1:0] lo_op;
      logic [OUT_W-1:0] hi_op;
      // Lower node keeps its weight; upper node gains SH zero bits below.
      assign lo_op = OUT_W'(in_bus[(2*n)*IN_W +: IN_W]);
      assign hi_op = OUT_W'({in_bus[(2*n+1)*IN_W +: IN_W], {SH{1'b0}}});
      assign sum_bus[n*OUT_W +: OUT_W] = lo_op + hi_op;
   end

   if (CUT) begin : g_cut
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_v   <= 1'b0;
            out_bus <= '0;
         end else begin
            out_v   <= in_v;
            out_bus <= sum_bus;
         end
      end
   end else begin : g_thru
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign out_v   = in_v;
      assign out_bus = sum_bus;
   end

endmodule

// File: rtl/mul_tree.sv
module mul_tree
   import mul_tree_pkg::*;
#(
   parameter int WIDTH    = 8,
   parameter int CUT_MASK = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               op_valid,
   input  logic [WIDTH-1:0]   op_a,
   input  logic [WIDTH-1:0]   op_b,
   output logic               res_valid,
   output logic [2*WIDTH-1:0] res_prod
);

   localparam int LEVELS  = $clog2(WIDTH);
   localparam int LATENCY = cut_count(CUT_MASK, LEVELS);

   initial begin
      assert (WIDTH >= 2 && (1 << LEVELS) == WIDTH)
         else $error("mul_tree: WIDTH must be a power of two, at least 2");
      assert (CUT_MASK >= 0 && CUT_MASK < (1 << LEVELS))
         else $error("mul_tree: CUT_MASK has bits beyond the tree depth");
      assert (node_w(WIDTH, LEVELS) == 2 * WIDTH)
         else $error("mul_tree: final node width mismatch");
   end

   for (genvar k = 0; k <= LEVELS; k++) begin : g_lvl
      localparam int NN = WIDTH >> k;
      localparam int NW = node_w(WIDTH, k);
      logic          vld;
      logic [NN*NW-1:0] bus;

      if (k == 0) begin : g_src
         mul_tree_pp #(.WIDTH(WIDTH)) u_pp (
            .op_a   (op_a),
            .op_b   (op_b),
            .pp_bus (bus)
         );
         assign vld = op_valid;
      end else begin : g_add
         mul_tree_level #(
            .IN_W     (node_w(WIDTH, k-1)),
            .OUT_W    (NW),
            .NODES_IN (2*NN),
            .SH       (1 << (k-1)),
            .CUT      (((CUT_MASK >> (k-1)) & 1) != 0)
         ) u_level (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_v    (g_lvl[k-1].vld),
            .in_bus  (g_lvl[k-1].bus),
            .out_v   (vld),
            .out_bus (bus)
         );
      end
   end

   assign res_valid = g_lvl[LEVELS].vld;
   assign res_prod  = g_lvl[LEVELS].bus;

endmodule

// File: rtl/mul_tree_chk.sv
module mul_tree_chk #(
   parameter int WIDTH   = 8,
   parameter int LATENCY = 0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               op_valid,
   input logic [WIDTH-1:0]   op_a,
   input logic [WIDTH-1:0]   op_b,
   input logic               res_valid,
   input logic [2*WIDTH-1:0] res_prod
);

   localparam logic [2*WIDTH-1:0] MAXP =
      (2*WIDTH)'({WIDTH{1'b1}}) * (2*WIDTH)'({WIDTH{1'b1}});

   logic             dv;
   logic [WIDTH-1:0] da;
   logic [WIDTH-1:0] db;

   if (LATENCY == 0) begin : g_nodly
      assign dv = op_valid;
      assign da = op_a;
      assign db = op_b;
   end else begin : g_dly
      logic [LATENCY-1:0] sv;
      logic [WIDTH-1:0]   sa [LATENCY];
      logic [WIDTH-1:0]   sb [LATENCY];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sv <= '0;
            for (int i = 0; i < LATENCY; i++) begin
               sa[i] <= '0;
               sb[i] <= '0;
            end
         end else begin
            sv[0] <= op_valid;
            sa[0] <= op_a;
            sb[0] <= op_b;
            for (int i = 1; i < LATENCY; i++) begin
               sv[i] <= sv[i-1];
               sa[i] <= sa[i-1];
               sb[i] <= sb[i-1];
            end
         end
      end
      assign dv = sv[LATENCY-1];
      assign da = sa[LATENCY-1];
      assign db = sb[LATENCY-1];
   end

   assert_exact_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
      dv |-> (res_prod == (2*WIDTH)'(da) * (2*WIDTH)'(db)));

   assert_zero_operand_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dv && (da == '0 || db == '0)) |-> (res_prod == '0));

   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      res_prod <= MAXP);

   assert_valid_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid == dv);

endmodule

bind mul_tree mul_tree_chk #(
   .WIDTH   (WIDTH),
   .LATENCY (LATENCY)
) u_mul_tree_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op_a      (op_a),
   .op_b      (op_b),
   .res_valid (res_valid),
   .res_prod  (res_prod)
);

// File: tb/test_mul_tree.sv
module test_mul_tree;

   localparam int W  = 8;
   localparam int PW = 2 * W;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n    = 1'b0;
   logic          op_valid = 1'b0;
   logic [W-1:0]  op_a     = '0;
   logic [W-1:0]  op_b     = '0;
   logic          c_valid, p_valid;
   logic [PW-1:0] c_prod,  p_prod;

   int checks = 0;
   int errors = 0;

   // Inputs present at the previous two sampling points (index 1 is older).
   logic         hv [2] = '{1'b0, 1'b0};
   logic [W-1:0] ha [2] = '{'0, '0};
   logic [W-1:0] hb [2] = '{'0, '0};

   mul_tree #(.WIDTH(W)) i_mul_tree (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
      .res_valid(c_valid), .res_prod(c_prod)
   );

   // Cuts after levels 1 and 3: two cycles of latency.
   mul_tree #(.WIDTH(W), .CUT_MASK(5)) i_mul_tree_piped (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
      .res_valid(p_valid), .res_prod(p_prod)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [W-1:0] a, input logic [W-1:0] b);
      if (a == 0 || b == 0)             return "R3";
      if (a == 8'hFF && b == 8'hFF)     return "R4";
      if ($countones(a) == 1)           return "R2";
      return "R1";
   endfunction

   task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b);
      @(negedge clk);
      check("R5 piped valid", int'(p_valid), int'(hv[1]));
      if (hv[1]) check("R6 piped product", int'(p_prod), int'(ha[1]) * int'(hb[1]));
      hv[1] = hv[0]; ha[1] = ha[0]; hb[1] = hb[0];
      hv[0] = v;     ha[0] = a;     hb[0] = b;
      op_valid = v; op_a = a; op_b = b;
      #1;
      check("R5 comb valid", int'(c_valid), int'(v));
      if (v) check(tag_of(a, b), int'(c_prod), int'(a) * int'(b));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R7: cut registers cleared while reset is held
      check("R7 reset valid", int'(p_valid), 0);
      check("R7 reset product", int'(p_prod), 0);
      rst_n = 1'b1;

      // R1..R4: exhaustive sweep, one pair per cycle (R6 back-to-back)
      for (int a = 0; a < 256; a++) begin
         for (int b = 0; b < 256; b++) begin
            step(1'b1, W'(a), W'(b));
         end
      end

      // R4: all-ones product value stated explicitly
      step(1'b1, 8'hFF, 8'hFF);
      check("R4 max value", int'(c_prod), 65025);

      // R5/R6: gaps in the valid stream
      for (int i = 0; i < 12; i++) begin
         step((i % 3) == 0, W'(i * 37 + 5), W'(i * 91 + 3));
      end
      step(1'b0, '0, '0);
      step(1'b0, '0, '0);

      // R7: reset in the middle of a stream drops in-flight results
      step(1'b1, 8'hC3, 8'h5A);
      @(negedge clk);
      rst_n = 1'b0;
      op_valid = 1'b0;
      hv[0] = 1'b0; hv[1] = 1'b0;
      #1;
      check("R7 mid reset valid", int'(p_valid), 0);
      check("R7 mid reset product", int'(p_prod), 0);
      @(negedge clk);
      check("R7 held reset valid", int'(p_valid), 0);
      rst_n = 1'b1;
      step(1'b1, 8'h80, 8'hFF);
      step(1'b1, 8'h01, 8'h7F);
      step(1'b0, '0, '0);
      step(1'b0, '0, '0);
      step(1'b0, '0, '0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule